// File: doc/BRIEF.md
# Haptic Actuator Drive and Brake Sequencer

This block steps a vibration actuator through one drive cycle for each period in which a level enable input is held high. A cycle opens with a start-up boost interval, continues as steady drive for as long as enable stays high, and closes with a brake interval. The brake length follows the length of the drive that just ended, up to a fixed cap. All timing is counted in ticks of a 1 ms timebase. The timebase is prescaled from the system clock, and the prescaler restarts at every phase change so that each phase is a whole number of ticks long.

The outputs are registered phase flags, a direction request and a level request for a downstream bridge driver. The boost length, the resonance period (which is also the minimum drive length), the boost and drive levels, and a brake enable come in as configuration inputs. After reset is released the block holds off for a lockout period. During that period it ignores enable.

Top module: `haptic_drive_seq`

## Requirements
- R1: From reset release, `o_ready` stays low for exactly LOCKOUT_MS ticks (LOCKOUT_MS x TICK_DIV clock cycles). During that time no phase flag is raised, whatever `i_en` does.
- R2: When ready and idle, a high `i_en` sampled at a clock edge starts a cycle at that edge. During boost and drive `o_dir` is 2'b01 (forward). During brake it is 2'b10 (reverse). Otherwise it is 2'b00.
- R3: Boost lasts `i_boost_ms` ticks and then gives way to drive. With `i_boost_ms` = 0 the cycle starts directly in drive. `o_level` carries `i_boost_lvl` during boost and `i_drive_lvl` during drive and brake. It is 0 otherwise.
- R4: Once the minimum length is met, drive ends at the first clock edge at which `i_en` is sampled low.
- R5: A cycle is never shorter than `i_reso_ms` ticks from its start. A shorter enable pulse is stretched to that length.
- R6: Brake length in ticks is the number of whole ticks the drive lasted, capped at BRAKE_CAP_MS.
- R7: With `i_brake_en` low, or with a computed brake length of zero, the sequencer returns from drive straight to idle.
- R8: Enable is ignored during brake. A new cycle starts only if `i_en` is high after brake has ended.
- R9: At most one of `o_boost`, `o_drive` and `o_brake` is high at any time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| i_en | input | 1 | Level enable: high requests drive |
| i_brake_en | input | 1 | Allows the brake phase after drive |
| i_boost_ms | input | MS_W | Start-up boost length in ticks |
| i_reso_ms | input | MS_W | Resonance period in ticks, the minimum drive length |
| i_boost_lvl | input | LVL_W | Level requested during boost |
| i_drive_lvl | input | LVL_W | Level requested during drive and brake |
| o_ready | output | 1 | Lockout after reset has expired |
| o_boost | output | 1 | Boost phase active |
| o_drive | output | 1 | Steady drive phase active |
| o_brake | output | 1 | Brake phase active |
| o_dir | output | 2 | Direction request: 01 forward, 10 reverse, 00 off |
| o_level | output | LVL_W | Level request for the bridge |

## Verification
Each phase flag rises at the clock edge that samples the triggering input. A flag is therefore visible at the falling edge that follows; for example, drive shows in the same cycle in which enable was first sampled high. Phase lengths are whole multiples of the tick divider, because the prescaler restarts on every phase change. The bench drives inputs on falling edges and samples at falling edges. It counts the cycles spent in each phase and compares those counts with closed-form values. Drive length is the larger of the enable length and the resonance period. Boost length is the smaller of the boost setting and the drive length. Brake length is the capped whole-tick drive length times the divider. The lockout is checked as an exact cycle count from reset release to `o_ready`.

// File: rtl/haptic_seq_pkg.sv
package haptic_seq_pkg;

    typedef enum logic [2:0] {
        PH_LOCK  = 3'd0,
        PH_IDLE  = 3'd1,
        PH_BOOST = 3'd2,
        PH_DRIVE = 3'd3,
        PH_BRAKE = 3'd4
    } phase_e;

    localparam logic [1:0] DIR_OFF = 2'b00;
    localparam logic [1:0] DIR_FWD = 2'b01;
    localparam logic [1:0] DIR_REV = 2'b10;

endpackage

// File: rtl/haptic_tick_gen.sv
module haptic_tick_gen #(
    parameter int TICK_DIV = 250000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic i_clr,
    output logic o_tick
);
    localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
    localparam logic [PW-1:0] LAST = PW'(TICK_DIV - 1);

    logic [PW-1:0] pre_d, pre_q;

    assign o_tick = (pre_q == LAST);

    always_comb begin
        pre_d = pre_q + PW'(1);
        if (i_clr || o_tick) pre_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

endmodule

// File: rtl/haptic_brake_calc.sv
module haptic_brake_calc #(
    parameter int MS_W         = 8,
    parameter int BRAKE_CAP_MS = 30
) (
    input  logic [MS_W-1:0] i_drive_ticks,
    output logic [MS_W-1:0] o_brake_ticks
);
    localparam logic [MS_W-1:0] CAP = MS_W'(BRAKE_CAP_MS);

    // R6: brake length follows drive length up to the cap
    always_comb begin
        o_brake_ticks = (i_drive_ticks > CAP) ? CAP : i_drive_ticks;
    end

endmodule

// File: rtl/haptic_phase_fsm.sv
module haptic_phase_fsm
    import haptic_seq_pkg::*;
#(
    parameter int MS_W         = 8,
    parameter int LOCKOUT_MS   = 200,
    parameter int BRAKE_CAP_MS = 30
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            i_tick,
    input  logic            i_en,
    input  logic            i_brake_en,
    input  logic [MS_W-1:0] i_boost_ms,
    input  logic [MS_W-1:0] i_reso_ms,
    output logic            o_tick_clr,
    output phase_e          o_phase
);
    localparam int LK_W  = $clog2(LOCKOUT_MS + 1);
    localparam int TMR_W = (MS_W > LK_W) ? MS_W : LK_W;
    localparam logic [TMR_W-1:0] LOCK_T = TMR_W'(LOCKOUT_MS);

    typedef struct packed {
        phase_e            ph;
        logic [TMR_W-1:0]  tmr;
        logic [MS_W-1:0]   run;
        logic [MS_W-1:0]   blen;
    } seq_t;

    seq_t st_d, st_q;

    logic [TMR_W-1:0] tmr_now;
    logic [MS_W-1:0]  run_now;
    logic [MS_W-1:0]  cap_len;
    logic             drv_act;

    assign tmr_now = st_q.tmr + TMR_W'(i_tick);
    assign run_now = (i_tick && (st_q.run != {MS_W{1'b1}})) ? st_q.run + MS_W'(1) : st_q.run;
    assign drv_act = (st_q.ph == PH_BOOST) || (st_q.ph == PH_DRIVE);

    haptic_brake_calc #(
        .MS_W         (MS_W),
        .BRAKE_CAP_MS (BRAKE_CAP_MS)
    ) u_brake_calc (
        .i_drive_ticks (run_now),
        .o_brake_ticks (cap_len)
    );

    always_comb begin
        st_d = st_q;
        unique case (st_q.ph)
            PH_LOCK: begin
                st_d.tmr = tmr_now;
                if (tmr_now >= LOCK_T) begin
                    st_d.ph  = PH_IDLE;
                    st_d.tmr = '0;
                end
            end
            PH_IDLE: begin
                if (i_en) begin
                    st_d.ph  = (i_boost_ms == '0) ? PH_DRIVE : PH_BOOST;
                    st_d.tmr = '0;
                    st_d.run = '0;
                end
            end
            PH_BOOST, PH_DRIVE: begin
                st_d.run = run_now;
                st_d.tmr = tmr_now;
                if (!i_en && (run_now >= i_reso_ms)) begin
                    st_d.blen = cap_len;
                    st_d.tmr  = '0;
                    st_d.ph   = (i_brake_en && (cap_len != '0)) ? PH_BRAKE : PH_IDLE;
                end else if ((st_q.ph == PH_BOOST) && (tmr_now >= TMR_W'(i_boost_ms))) begin
                    st_d.ph  = PH_DRIVE;
                    st_d.tmr = '0;
                end
            end
            PH_BRAKE: begin
                st_d.tmr = tmr_now;
                if (tmr_now >= TMR_W'(st_q.blen)) begin
                    st_d.ph  = PH_IDLE;
                    st_d.tmr = '0;
                end
            end
            default: st_d.ph = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.ph   <= PH_LOCK;
            st_q.tmr  <= '0;
            st_q.run  <= '0;
            st_q.blen <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign o_tick_clr = (st_d.ph != st_q.ph);
    assign o_phase    = st_q.ph;

    AST_LOCK_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_LOCK && !i_tick) |=> (st_q.ph == PH_LOCK)) else $error("lockout left early"); // R1
    AST_START_ON_EN: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_IDLE && i_en) |=> (st_q.ph == PH_BOOST || st_q.ph == PH_DRIVE)) else $error("enable did not start"); // R2
    AST_NO_EARLY_END: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_act && (run_now < i_reso_ms)) |=> (st_q.ph == PH_BOOST || st_q.ph == PH_DRIVE)) else $error("drive shorter than period"); // R5
    AST_BRAKE_CAP: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_BRAKE) |-> (st_q.blen != '0 && st_q.blen <= MS_W'(BRAKE_CAP_MS))) else $error("brake length out of range"); // R6
    AST_NO_BRAKE_WHEN_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_act && !i_brake_en) |=> (st_q.ph != PH_BRAKE)) else $error("brake while disabled"); // R7
    AST_BRAKE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q.ph == PH_BRAKE && !i_tick) |=> (st_q.ph == PH_BRAKE)) else $error("brake cut short"); // R8

endmodule

// File: rtl/haptic_drive_seq.sv
module haptic_drive_seq
    import haptic_seq_pkg::*;
#(
    parameter int TICK_DIV     = 250000,
    parameter int MS_W         = 8,
    parameter int LVL_W        = 4,
    parameter int LOCKOUT_MS   = 200,
    parameter int BRAKE_CAP_MS = 30
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             i_en,
    input  logic             i_brake_en,
    input  logic [MS_W-1:0]  i_boost_ms,
    input  logic [MS_W-1:0]  i_reso_ms,
    input  logic [LVL_W-1:0] i_boost_lvl,
    input  logic [LVL_W-1:0] i_drive_lvl,
    output logic             o_ready,
    output logic             o_boost,
    output logic             o_drive,
    output logic             o_brake,
    output logic [1:0]       o_dir,
    output logic [LVL_W-1:0] o_level
);
    logic   tick;
    logic   tick_clr;
    phase_e phase;

    haptic_tick_gen #(
        .TICK_DIV (TICK_DIV)
    ) u_tick (
        .clk    (clk),
        .rst_n  (rst_n),
        .i_clr  (tick_clr),
        .o_tick (tick)
    );

    haptic_phase_fsm #(
        .MS_W         (MS_W),
        .LOCKOUT_MS   (LOCKOUT_MS),
        .BRAKE_CAP_MS (BRAKE_CAP_MS)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .i_tick     (tick),
        .i_en       (i_en),
        .i_brake_en (i_brake_en),
        .i_boost_ms (i_boost_ms),
        .i_reso_ms  (i_reso_ms),
        .o_tick_clr (tick_clr),
        .o_phase    (phase)
    );

    always_comb begin
        o_ready = (phase != PH_LOCK);
        o_boost = (phase == PH_BOOST);
        o_drive = (phase == PH_DRIVE);
        o_brake = (phase == PH_BRAKE);
        o_dir   = DIR_OFF;
        o_level = '0;
        unique case (phase)
            PH_BOOST: begin o_dir = DIR_FWD; o_level = i_boost_lvl; end
            PH_DRIVE: begin o_dir = DIR_FWD; o_level = i_drive_lvl; end
            PH_BRAKE: begin o_dir = DIR_REV; o_level = i_drive_lvl; end
            default:  begin o_dir = DIR_OFF; o_level = '0; end
        endcase
    end

    AST_ONE_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({o_boost, o_drive, o_brake}) && (o_ready || !(o_boost || o_drive || o_brake))) else $error("phase flags overlap"); // R9

endmodule

// File: tb/haptic_drive_seq_tb.sv
module haptic_drive_seq_tb;
    localparam int DIV   = 4;
    localparam int MS_W  = 8;
    localparam int LVL_W = 4;
    localparam int LOCK  = 200;
    localparam int CAP   = 30;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             i_en = 1'b0;
    logic             i_brake_en = 1'b0;
    logic [MS_W-1:0]  i_boost_ms = '0;
    logic [MS_W-1:0]  i_reso_ms = '0;
    logic [LVL_W-1:0] i_boost_lvl = '0;
    logic [LVL_W-1:0] i_drive_lvl = '0;
    logic             o_ready, o_boost, o_drive, o_brake;
    logic [1:0]       o_dir;
    logic [LVL_W-1:0] o_level;

    int n_vec = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    haptic_drive_seq #(
        .TICK_DIV (DIV), .MS_W (MS_W), .LVL_W (LVL_W),
        .LOCKOUT_MS (LOCK), .BRAKE_CAP_MS (CAP)
    ) u_dut (
        .clk (clk), .rst_n (rst_n), .i_en (i_en), .i_brake_en (i_brake_en),
        .i_boost_ms (i_boost_ms), .i_reso_ms (i_reso_ms),
        .i_boost_lvl (i_boost_lvl), .i_drive_lvl (i_drive_lvl),
        .o_ready (o_ready), .o_boost (o_boost), .o_drive (o_drive), .o_brake (o_brake),
        .o_dir (o_dir), .o_level (o_level)
    );

    always #2 clk = ~clk;

    function automatic int exp_drive(int h, int reso);
        return (h > reso * DIV) ? h : reso * DIV;
    endfunction

    function automatic int exp_boost(int b, int d);
        return (b * DIV < d) ? b * DIV : d;
    endfunction

    function automatic int exp_brake(int d, bit bren);
        int t;
        t = d / DIV;
        if (t > CAP) t = CAP;
        return bren ? t * DIV : 0;
    endfunction

    task automatic chk(bit ok, string tag, int act, int exp);
        n_vec++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic report();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    endtask

    // One drive cycle: enable held for h sampled edges, phases counted per cycle
    task automatic xact(int h, int reso, int boost, bit bren, bit holdoff);
        int cyc, act, bst, brk, late, bad_dir, bad_lvl, pulse, d;
        bit seen_brk;
        cyc = 0; act = 0; bst = 0; brk = 0; late = 0; bad_dir = 0; bad_lvl = 0;
        pulse = 0; seen_brk = 1'b0;
        for (int g = 0; g < 2000; g++) begin
            @(negedge clk);
            if (o_ready && !o_boost && !o_drive && !o_brake) break;
        end
        i_reso_ms   = MS_W'(reso);
        i_boost_ms  = MS_W'(boost);
        i_brake_en  = bren;
        i_boost_lvl = LVL_W'($urandom % 16);
        i_drive_lvl = LVL_W'($urandom % 16);
        i_en = 1'b1;
        for (int g = 0; g < 3000; g++) begin
            @(negedge clk);
            cyc++;
            if (o_boost || o_drive) begin
                if (seen_brk) late++; else act++;
                if (o_dir != 2'b01) bad_dir++;
            end
            if (o_boost) begin
                bst++;
                if (o_level != i_boost_lvl) bad_lvl++;
            end
            if (o_drive && o_level != i_drive_lvl) bad_lvl++;
            if (o_brake) begin
                brk++;
                seen_brk = 1'b1;
                if (o_dir != 2'b10) bad_dir++;
                if (o_level != i_drive_lvl) bad_lvl++;
                if (holdoff && pulse == 0) begin i_en = 1'b1; pulse = 1; end
                else if (pulse == 1) begin i_en = 1'b0; pulse = 2; end
            end
            if (cyc == h) i_en = 1'b0;
            if (!o_boost && !o_drive && !o_brake && cyc > h && !i_en) break;
        end
        for (int g = 0; g < 3; g++) begin
            @(negedge clk);
            if (o_boost || o_drive) late++;
        end
        d = exp_drive(h, reso);
        chk(act == d, "R4/R5 drive length", act, d);
        chk(bst == exp_boost(boost, d), "R3 boost length", bst, exp_boost(boost, d));
        chk(brk == exp_brake(d, bren), bren ? "R6 brake length" : "R7 no brake", brk, exp_brake(d, bren));
        chk(bad_dir == 0, "R2 direction", bad_dir, 0);
        chk(bad_lvl == 0, "R3 level", bad_lvl, 0);
        if (holdoff) chk(late == 0, "R8 enable ignored in brake", late, 0);
    endtask

    initial begin
        #(4 * 150000);
        n_vec++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        report();
    end

    initial begin
        int cnt, h, reso, bst, d;
        bit bren, hold;
        void'($urandom(32'd5150));
        i_en = 1'b1;
        repeat (3) @(negedge clk);
        // reset state
        chk(!o_ready && !o_boost && !o_drive && !o_brake && o_dir == 2'b00 && o_level == '0,
            "R1 reset state", {o_ready, o_boost, o_drive, o_brake}, 0);
        rst_n = 1'b1;
        // R1: lockout length with enable held high
        cnt = 0;
        begin
            int busy;
            busy = 0;
            for (int g = 0; g < 5000; g++) begin
                @(negedge clk);
                cnt++;
                if (o_ready) break;
                if (o_boost || o_drive || o_brake) busy++;
            end
            chk(cnt == LOCK * DIV, "R1 lockout cycles", cnt, LOCK * DIV);
            chk(busy == 0, "R1 quiet during lockout", busy, 0);
        end
        @(negedge clk);
        chk(o_drive && !o_boost, "R2 start right after lockout", {o_boost, o_drive}, 1);
        i_en = 1'b0;
        for (int g = 0; g < 2000; g++) begin
            @(negedge clk);
            if (!o_boost && !o_drive && !o_brake) break;
        end
        // directed corners
        xact(3, 10, 0, 1'b0, 1'b0);      // R5 stretch, R7 no brake, R3 zero boost
        xact(200, 2, 3, 1'b1, 1'b0);     // R6 cap at 30 ticks
        xact(120, 2, 2, 1'b1, 1'b0);     // R6 exactly 30 ticks
        xact(119, 2, 2, 1'b1, 1'b0);     // R6 29 ticks
        xact(60, 5, 40, 1'b1, 1'b1);     // R3 boost cut by drive end, R8 hold-off
        xact(2, 0, 0, 1'b1, 1'b0);       // R7 zero brake length
        // constrained random
        for (int i = 0; i < 30; i++) begin
            h    = 1 + int'($urandom % 160);
            reso = int'($urandom % 30);
            bst  = int'($urandom % 8);
            bren = ($urandom % 4) != 0;
            d    = exp_drive(h, reso);
            hold = bren && (exp_brake(d, bren) >= 8) && (($urandom % 2) != 0);
            xact(h, reso, bst, bren, hold);
        end
        report();
    end

endmodule